// File: doc/BRIEF.md
# Headphone Amplifier Control Slave (Two-Wire Bus)

This block is the digital control front end of a stereo headphone amplifier. It listens on a two-wire serial bus (SCL clock, SDA data) as a slave with the fixed 7-bit address 0x60. Both bus lines are resynchronised onto a faster system clock. A write transaction carries a register index byte and then one data byte. A read returns the register selected by the most recent index byte. The block answers a read with a repeated START and the read direction bit. It drives SDA only by pulling it low, through the `sda_pull` output.

The register contents are presented as decoded control outputs:
- global power-down;
- per-channel amplifier enables;
- per-channel mute;
- a 5-bit level code;
- a low-distortion mode bit;
- per-channel high-impedance bits.

The level code is also converted into a signed gain in dB that follows a piecewise law. Above code 16 each step is 1 dB, from 8 to 16 each step is 2 dB, and below 8 each step is 4 dB.

After any write that sets the power-down bit, a lockout of about 3 ms (a counter sized from the system clock frequency) begins. During the lockout, register writes are still acknowledged on the bus but are discarded. The bus engine is a state machine with ten states:
- IDLE waits for START.
- ADDR shifts in the address byte.
- ADDR_ACK acknowledges a match; a mismatch goes to SKIP.
- REG shifts in the index byte.
- REG_ACK acknowledges the index byte.
- DATA shifts in the data byte.
- DATA_ACK acknowledges the data byte, then goes to SKIP.
- RD_BYTE shifts out a byte.
- RD_ACK samples the master's acknowledge. An ACK reloads RD_BYTE and a NACK goes to SKIP.
- SKIP waits out the rest of the transaction.

Transitions are also forced by bus conditions. From any state, START leads to ADDR and STOP leads to IDLE.

Top module: `audio_ctl_i2c`

## Requirements
- R1: Only the address 0x60 (bits sent MSB first, R/W as the eighth bit, 0 = write, 1 = read) is acknowledged. Any other address gets no ACK, and its transaction changes no output.
- R2: In a write, the byte after the address selects a register and the next byte is stored into it. The slave pulls SDA low in the ninth clock after each of the three bytes.
- R3: After reset, power-down and both mutes read 1. Every other control output is 0, the gain is -59 dB, and SDA is released.
- R4: Register 0x01 holds: bit 7 = left enable, bit 6 = right enable, bit 0 = power-down. Bit 1 is read-only and reads the thermal flag input; writing it has no effect.
- R5: Register 0x02 holds: bit 7 = left mute, bit 6 = right mute, bits 5:1 = level code.
- R6: Register 0x03 holds: bit 3 = low-distortion mode, bit 1 = left high-impedance, bit 0 = right high-impedance. All other bits read 0.
- R7: Register 0x04 reads 0x40 and ignores writes. An unimplemented index reads 0x00 and ignores writes.
- R8: Reads return the selected register MSB first, one bit per SCL clock, starting right after the address ACK. An index set in an earlier write is kept for the read.
- R9: Gain in dB is -59 + 4c for code c < 8, -27 + 2(c - 8) for 8 <= c < 16, and -11 + (c - 16) for c >= 16. The gain lies within -59..+4 and rises with the code.
- R10: A write that sets power-down starts a lockout of LOCK_US microseconds. Within the lockout, addresses are still acknowledged but register writes are dropped. After it, writes take effect again.
- R11: A STOP returns the slave to idle with SDA released. A new START aborts any partial transaction, and the next full write then takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl | input | 1 | Bus clock line |
| sda_in | input | 1 | Bus data line as seen on the wire |
| therm_flag | input | 1 | Thermal protection status, read back in register 0x01 bit 1 |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain drive) |
| shutdown | output | 1 | Global power-down |
| amp_en_l | output | 1 | Left amplifier enable |
| amp_en_r | output | 1 | Right amplifier enable |
| mute_l | output | 1 | Left mute |
| mute_r | output | 1 | Right mute |
| vol_code | output | 5 | Level code |
| low_dist | output | 1 | Low-distortion mode |
| hiz_l | output | 1 | Left output high-impedance |
| hiz_r | output | 1 | Right output high-impedance |
| gain_db | output | 7 | Signed gain in dB decoded from the level code |

## Verification
The line synchronisers and the edge detector add three system clocks of delay. A stored byte therefore reaches the control outputs about four clocks after the eighth SCL falling edge of the data byte. The bench samples those outputs only after the STOP and a ten-clock settle. ACK bits and read bits change about four clocks after an SCL falling edge, so the bench samples SDA in the middle of the following SCL high phase. Half an SCL period lies between that change and the sample. The lockout lasts LOCK_US microseconds of system clock, so the bench issues one write well inside that window and one well after it.

// File: rtl/ac_pkg.sv
package ac_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_REG,
        ST_REG_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_SKIP
    } bus_st_t;

    localparam logic [6:0] DEV_ADDR  = 7'h60;
    localparam logic [7:0] IX_MODE   = 8'h01;
    localparam logic [7:0] IX_LEVEL  = 8'h02;
    localparam logic [7:0] IX_OUT    = 8'h03;
    localparam logic [7:0] IX_ID     = 8'h04;
    localparam logic [7:0] ID_VALUE  = 8'h40;

    localparam int DB_FLOOR  = -59;
    localparam int KNEE_LO   = 8;
    localparam int KNEE_HI   = 16;

    typedef struct packed {
        logic       en_l;
        logic       en_r;
        logic       pdn;
        logic       mute_l;
        logic       mute_r;
        logic [4:0] level;
        logic       lowd;
        logic       hiz_l;
        logic       hiz_r;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{en_l: 1'b0, en_r: 1'b0, pdn: 1'b1,
                                   mute_l: 1'b1, mute_r: 1'b1, level: 5'd0,
                                   lowd: 1'b0, hiz_l: 1'b0, hiz_r: 1'b0};

    // piecewise level law: 4 dB, then 2 dB, then 1 dB per step
    function automatic logic signed [6:0] code_to_db(input logic [4:0] c);
        int ci;
        int v;
        int at_lo;
        int at_hi;
        ci    = int'(c);
        at_lo = DB_FLOOR + 4 * KNEE_LO;
        at_hi = at_lo + 2 * (KNEE_HI - KNEE_LO);
        if (ci < KNEE_LO)
            v = DB_FLOOR + 4 * ci;
        else if (ci < KNEE_HI)
            v = at_lo + 2 * (ci - KNEE_LO);
        else
            v = at_hi + (ci - KNEE_HI);
        return 7'(v);
    endfunction

endpackage

// File: rtl/ac_sync.sv
module ac_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    for (genvar g = 0; g < W; g++) begin : g_line
        logic [2:0] pipe;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pipe <= 3'b111;
            else
                pipe <= {pipe[1:0], din[g]};
        end
        assign lvl[g]  = pipe[1];
        assign rise[g] = pipe[1] & ~pipe[2];
        assign fall[g] = ~pipe[1] & pipe[2];
    end
endmodule

// File: rtl/ac_bus_fsm.sv
module ac_bus_fsm
    import ac_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       sda_lvl,
    input  logic       start_p,
    input  logic       stop_p,
    input  logic [7:0] rd_data,
    output logic       sda_pull,
    output logic       wr_stb,
    output logic [7:0] wr_data,
    output logic [7:0] ptr,
    output bus_st_t    st
);
    localparam logic [3:0] BITS = 4'd8;

    bus_st_t    nx;
    logic [7:0] sh;
    logic [3:0] cnt;
    logic       nack;
    logic       byte_done;

    assign byte_done = scl_fall && (cnt == BITS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= ST_IDLE;
        else
            st <= nx;
    end

    always_comb begin
        nx = st;
        if (start_p)
            nx = ST_ADDR;
        else if (stop_p)
            nx = ST_IDLE;
        else begin
            unique case (st)
                ST_IDLE:     nx = ST_IDLE;
                ST_ADDR:     if (byte_done)
                                 nx = (sh[7:1] == DEV_ADDR) ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK: if (scl_fall) nx = sh[0] ? ST_RD_BYTE : ST_REG;
                ST_REG:      if (byte_done) nx = ST_REG_ACK;
                ST_REG_ACK:  if (scl_fall) nx = ST_DATA;
                ST_DATA:     if (byte_done) nx = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall) nx = ST_SKIP;
                ST_RD_BYTE:  if (scl_fall && cnt == BITS - 4'd1) nx = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) nx = nack ? ST_SKIP : ST_RD_BYTE;
                ST_SKIP:     nx = ST_SKIP;
                default:     nx = ST_IDLE;
            endcase
        end
    end

    // shift register, bit counter, index pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh   <= '0;
            cnt  <= '0;
            ptr  <= '0;
            nack <= 1'b1;
        end else if (start_p) begin
            cnt <= '0;
        end else begin
            unique case (st)
                ST_ADDR, ST_REG, ST_DATA: begin
                    if (scl_rise) begin
                        sh  <= {sh[6:0], sda_lvl};
                        cnt <= cnt + 4'd1;
                    end
                    if (byte_done) begin
                        cnt <= '0;
                        if (st == ST_REG)
                            ptr <= sh;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall && sh[0]) begin
                        sh  <= rd_data;
                        cnt <= '0;
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_fall) begin
                        sh  <= {sh[6:0], 1'b0};
                        cnt <= cnt + 4'd1;
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise)
                        nack <= sda_lvl;
                    if (scl_fall && !nack) begin
                        sh  <= rd_data;
                        cnt <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        sda_pull = 1'b0;
        wr_stb   = 1'b0;
        unique case (st)
            ST_ADDR_ACK, ST_REG_ACK, ST_DATA_ACK: sda_pull = 1'b1;
            ST_RD_BYTE:                           sda_pull = ~sh[7];
            ST_DATA:                              wr_stb   = byte_done;
            default: ;
        endcase
    end

    assign wr_data = sh;
endmodule

// File: rtl/ac_regs.sv
module ac_regs
    import ac_pkg::*;
#(
    parameter int CLK_HZ  = 10_000_000,
    parameter int LOCK_US = 3000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [7:0]       wr_data,
    input  logic [7:0]       ix,
    input  logic             therm,
    output logic [7:0]       rd_data,
    output ctl_t             ctl,
    output logic             lock_active,
    output logic signed [6:0] gain
);
    localparam int LOCK_CYC = (CLK_HZ / 1_000_000) * LOCK_US;
    localparam int CW       = $clog2(LOCK_CYC + 1);

    logic [CW-1:0] lock_cnt;
    logic          wr_ok;

    assign lock_active = (lock_cnt != '0);
    assign wr_ok       = wr_stb && !lock_active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl      <= CTL_RESET;
            lock_cnt <= '0;
        end else begin
            if (lock_active)
                lock_cnt <= lock_cnt - 1'b1;
            if (wr_ok) begin
                case (ix)
                    IX_MODE: begin
                        ctl.en_l <= wr_data[7];
                        ctl.en_r <= wr_data[6];
                        ctl.pdn  <= wr_data[0];
                        if (wr_data[0])
                            lock_cnt <= CW'(LOCK_CYC);
                    end
                    IX_LEVEL: begin
                        ctl.mute_l <= wr_data[7];
                        ctl.mute_r <= wr_data[6];
                        ctl.level  <= wr_data[5:1];
                    end
                    IX_OUT: begin
                        ctl.lowd  <= wr_data[3];
                        ctl.hiz_l <= wr_data[1];
                        ctl.hiz_r <= wr_data[0];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (ix)
            IX_MODE:  rd_data = {ctl.en_l, ctl.en_r, 4'b0, therm, ctl.pdn};
            IX_LEVEL: rd_data = {ctl.mute_l, ctl.mute_r, ctl.level, 1'b0};
            IX_OUT:   rd_data = {4'b0, ctl.lowd, 1'b0, ctl.hiz_l, ctl.hiz_r};
            IX_ID:    rd_data = ID_VALUE;
            default:  rd_data = 8'h00;
        endcase
    end

    assign gain = code_to_db(ctl.level);
endmodule

// File: rtl/audio_ctl_i2c.sv
module audio_ctl_i2c
    import ac_pkg::*;
#(
    parameter int CLK_HZ  = 10_000_000,
    parameter int LOCK_US = 3000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl,
    input  logic              sda_in,
    input  logic              therm_flag,
    output logic              sda_pull,
    output logic              shutdown,
    output logic              amp_en_l,
    output logic              amp_en_r,
    output logic              mute_l,
    output logic              mute_r,
    output logic [4:0]        vol_code,
    output logic              low_dist,
    output logic              hiz_l,
    output logic              hiz_r,
    output logic signed [6:0] gain_db
);
    localparam int LINES = 2;
    localparam int L_SCL = 0;
    localparam int L_SDA = 1;

    logic [LINES-1:0] lvl;
    logic [LINES-1:0] rise;
    logic [LINES-1:0] fall;
    logic             start_p;
    logic             stop_p;
    logic             wr_stb;
    logic [7:0]       wr_data;
    logic [7:0]       ptr;
    logic [7:0]       rd_data;
    logic             lock_active;
    bus_st_t          bus_st;
    ctl_t             ctl;

    ac_sync #(.W(LINES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sda_in, scl}),
        .lvl  (lvl),
        .rise (rise),
        .fall (fall)
    );

    assign start_p = fall[L_SDA] && lvl[L_SCL];
    assign stop_p  = rise[L_SDA] && lvl[L_SCL];

    ac_bus_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_rise(rise[L_SCL]),
        .scl_fall(fall[L_SCL]),
        .sda_lvl (lvl[L_SDA]),
        .start_p (start_p),
        .stop_p  (stop_p),
        .rd_data (rd_data),
        .sda_pull(sda_pull),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .ptr     (ptr),
        .st      (bus_st)
    );

    ac_regs #(.CLK_HZ(CLK_HZ), .LOCK_US(LOCK_US)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb     (wr_stb),
        .wr_data    (wr_data),
        .ix         (ptr),
        .therm      (therm_flag),
        .rd_data    (rd_data),
        .ctl        (ctl),
        .lock_active(lock_active),
        .gain       (gain_db)
    );

    assign shutdown = ctl.pdn;
    assign amp_en_l = ctl.en_l;
    assign amp_en_r = ctl.en_r;
    assign mute_l   = ctl.mute_l;
    assign mute_r   = ctl.mute_r;
    assign vol_code = ctl.level;
    assign low_dist = ctl.lowd;
    assign hiz_l    = ctl.hiz_l;
    assign hiz_r    = ctl.hiz_r;
endmodule

// File: rtl/ac_chk.sv
module ac_chk
    import ac_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              stop_p,
    input logic              sda_pull,
    input logic              lock_active,
    input logic              shutdown,
    input ctl_t              ctl,
    input logic [4:0]        vol_code,
    input logic signed [6:0] gain_db,
    input bus_st_t           bus_st
);
    assert_stop_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |=> (bus_st == ST_IDLE));

    assert_stop_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |=> !sda_pull);

    assert_lock_on_pdn_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_active) |-> shutdown);

    assert_lock_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock_active) |-> $stable(ctl));

    assert_gain_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_db >= -7'sd59) && (gain_db <= 7'sd4));

    assert_gain_rises_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (vol_code > $past(vol_code)) |-> (gain_db > $past(gain_db)));
endmodule

bind audio_ctl_i2c ac_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_p     (stop_p),
    .sda_pull   (sda_pull),
    .lock_active(lock_active),
    .shutdown   (shutdown),
    .ctl        (ctl),
    .vol_code   (vol_code),
    .gain_db    (gain_db),
    .bus_st     (bus_st)
);

// File: tb/sim_audio_ctl_i2c.sv
`timescale 1ns/1ps
module sim_audio_ctl_i2c;
    localparam int CLK_NS   = 10;
    localparam int H        = 8;
    localparam int Q        = H / 2;
    localparam int TB_HZ    = 1_000_000;
    localparam int TB_LOCK  = 3000;
    localparam int LOCK_CYC = (TB_HZ / 1_000_000) * TB_LOCK;

    localparam int NV = 9;
    localparam logic [7:0] V_DATA [NV] = '{8'h00, 8'h42, 8'h8E, 8'hD0, 8'h12,
                                           8'h1E, 8'h20, 8'h36, 8'h3E};
    localparam int         V_GAIN [NV] = '{-59, -55, -31, -27, -25, -13, -11, 0, 4};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic therm = 1'b0;
    logic sda_bus;
    logic sda_pull, shutdown, amp_en_l, amp_en_r, mute_l, mute_r;
    logic low_dist, hiz_l, hiz_r;
    logic [4:0] vol_code;
    logic signed [6:0] gain_db;

    int nchk = 0;
    int nbad = 0;
    bit done = 0;

    always #(CLK_NS/2) clk = ~clk;
    assign sda_bus = sda_m & ~sda_pull;

    audio_ctl_i2c #(.CLK_HZ(TB_HZ), .LOCK_US(TB_LOCK)) u0 (
        .clk(clk), .rst_n(rst_n), .scl(scl_m), .sda_in(sda_bus),
        .therm_flag(therm), .sda_pull(sda_pull), .shutdown(shutdown),
        .amp_en_l(amp_en_l), .amp_en_r(amp_en_r), .mute_l(mute_l),
        .mute_r(mute_r), .vol_code(vol_code), .low_dist(low_dist),
        .hiz_l(hiz_l), .hiz_r(hiz_r), .gain_db(gain_db)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_start();
        tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1;
        tick(H); sda_m = 1'b0; tick(H); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b1;
        tick(H); sda_m = 1'b1; tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            tick(Q); sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(H); scl_m = 1'b0;
        end
        tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1;
        tick(H/2); ack = sda_bus; tick(H/2); scl_m = 1'b0;
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1;
            tick(H/2); b[i] = sda_bus; tick(H/2); scl_m = 1'b0;
        end
        tick(Q); sda_m = nack; tick(Q); scl_m = 1'b1; tick(H); scl_m = 1'b0;
    endtask

    task automatic write_reg(input logic [6:0] dev, input logic [7:0] ix,
                             input logic [7:0] d, output logic [2:0] acks);
        bus_start();
        send_byte({dev, 1'b0}, acks[2]);
        send_byte(ix, acks[1]);
        send_byte(d, acks[0]);
        bus_stop();
        tick(10);
    endtask

    task automatic read_reg(input logic [7:0] ix, output logic [7:0] d);
        logic a;
        bus_start();
        send_byte(8'hC0, a);
        send_byte(ix, a);
        bus_start();
        send_byte(8'hC1, a);
        recv_byte(1'b1, d);
        bus_stop();
        tick(10);
    endtask

    initial begin
        repeat (200_000) @(posedge clk);
        if (!done) begin
            nchk++;
            nbad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        logic [2:0] acks;
        logic [7:0] rd;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R3 reset state
        check("R3 shutdown", int'(shutdown), 1);
        check("R3 mute_l", int'(mute_l), 1);
        check("R3 mute_r", int'(mute_r), 1);
        check("R3 enables", int'({amp_en_l, amp_en_r}), 0);
        check("R3 level", int'(vol_code), 0);
        check("R3 gain", int'(gain_db), -59);
        check("R3 out ctl", int'({low_dist, hiz_l, hiz_r}), 0);
        check("R3 sda released", int'(sda_pull), 0);

        // R5 R9 R2 table walk over register 0x02
        for (int i = 0; i < NV; i++) begin
            write_reg(7'h60, 8'h02, V_DATA[i], acks);
            check("R2 acks", int'(acks), 0);
            check("R5 level", int'(vol_code), int'(V_DATA[i][5:1]));
            check("R5 mute_l", int'(mute_l), int'(V_DATA[i][7]));
            check("R5 mute_r", int'(mute_r), int'(V_DATA[i][6]));
            check("R9 gain", int'(gain_db), V_GAIN[i]);
        end

        // R4 mode register, thermal bit read-only
        write_reg(7'h60, 8'h01, 8'hC2, acks);
        check("R4 enables", int'({amp_en_l, amp_en_r}), 3);
        check("R4 shutdown", int'(shutdown), 0);
        read_reg(8'h01, rd);
        check("R4 R8 readback therm=0", int'(rd), 8'hC0);
        therm = 1'b1;
        read_reg(8'h01, rd);
        check("R4 readback therm=1", int'(rd), 8'hC2);
        therm = 1'b0;

        // R6 output register
        write_reg(7'h60, 8'h03, 8'hFF, acks);
        check("R6 low_dist", int'(low_dist), 1);
        check("R6 hiz", int'({hiz_l, hiz_r}), 3);
        read_reg(8'h03, rd);
        check("R6 readback", int'(rd), 8'h0B);

        // R8 level register read
        read_reg(8'h02, rd);
        check("R8 level read", int'(rd), int'(V_DATA[NV-1]));

        // R7 id and unimplemented
        read_reg(8'h04, rd);
        check("R7 id", int'(rd), 8'h40);
        write_reg(7'h60, 8'h04, 8'h00, acks);
        read_reg(8'h04, rd);
        check("R7 id after write", int'(rd), 8'h40);
        write_reg(7'h60, 8'h09, 8'h00, acks);
        read_reg(8'h09, rd);
        check("R7 unimpl read", int'(rd), 0);
        check("R7 unimpl write no effect", int'({low_dist, hiz_l, hiz_r, amp_en_l}), 15);

        // R1 foreign address
        write_reg(7'h61, 8'h02, 8'h00, acks);
        check("R1 no ack", int'(acks[2]), 1);
        check("R1 level kept", int'(vol_code), 31);
        check("R1 mutes kept", int'({mute_l, mute_r}), 0);

        // R11 aborted transaction then full write
        bus_start();
        send_byte(8'hC0, acks[0]);
        send_byte(8'h02, acks[0]);
        bus_stop();
        tick(10);
        check("R11 released after stop", int'(sda_bus), 1);
        check("R11 aborted write no effect", int'(vol_code), 31);
        write_reg(7'h60, 8'h02, 8'h10, acks);
        check("R11 write after abort", int'(vol_code), 8);

        // R10 lockout after power-down
        write_reg(7'h60, 8'h01, 8'hC1, acks);
        check("R10 shutdown set", int'(shutdown), 1);
        write_reg(7'h60, 8'h03, 8'h00, acks);
        check("R10 acks in lockout", int'(acks), 0);
        check("R10 write dropped", int'({low_dist, hiz_l, hiz_r}), 7);
        tick(LOCK_CYC + 200);
        write_reg(7'h60, 8'h03, 8'h00, acks);
        check("R10 write after lockout", int'({low_dist, hiz_l, hiz_r}), 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule